// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block runs one complete read or write cycle at a time on an asynchronous DRAM whose row and column addresses share one set of pins. A host hands it a request through a valid/ready handshake: a write flag, a full address and write data. The sequencer places the row half of the address on the shared pins and drops the active-low row strobe. It then switches the pins to the column half and drops the active-low column strobe. For a write it holds the write-enable low before the column strobe falls. For a read it samples the data-out pin once both access times have run out, and returns the value with a one-cycle response pulse.

Every timing limit is a parameter in whole controller clock cycles. One down-counter, loaded on entry to each timed state, holds the strobes for as long as the limits require. The controller has five states. IDLE is the only state that accepts a request. SETUP puts the row on the pins with both strobes high. ROW_WAIT has the row strobe low, and in its last cycle the pins already carry the column. COL_WAIT has both strobes low. PRECHARGE has both strobes high. The transitions are IDLE→SETUP on an accepted request, SETUP→ROW_WAIT after one cycle, ROW_WAIT→COL_WAIT when the row-to-column delay has run out, COL_WAIT→PRECHARGE when the column hold has run out, and PRECHARGE→IDLE when precharge is over. The column hold is the longest of four limits: the column pulse width, the column access time, the part of the row pulse width still to run, and the part of the row access time still to run. Precharge is long enough to cover both the precharge time and the rest of the full cycle time. T_RCD must be at least 2.

Top module: `dram_seq`

## Requirements
- R1: After reset both strobes and the write-enable are high, `req_ready` is 1 and `rsp_valid` is 0. `req_ready` is 1 only in IDLE, and a request is taken at a clock edge where `req_valid` and `req_ready` are both 1. In the cycle after that edge, `req_ready` is 0.
- R2: When `dram_ras_n` falls, `dram_a` holds the row, which is `req_addr[ROW_W+COL_W-1:COL_W]` of the accepted request.
- R3: When `dram_cas_n` falls, `dram_a` holds the column, which is `req_addr[COL_W-1:0]` of the accepted request.
- R4: The falling edge of `dram_cas_n` comes at least T_RCD cycles after the falling edge of `dram_ras_n`.
- R5: For a write, `dram_we_n` is already 0, and unchanged from the cycle before, when `dram_cas_n` falls. At that point `dram_din` equals the request's write data. A write produces no `rsp_valid` pulse.
- R6: For a read, `dram_we_n` stays 1 for the whole cycle. Exactly one `rsp_valid` pulse is produced, and `rsp_rdata` carries `dram_dout` as sampled no earlier than T_RAC cycles after the row strobe fell and T_CAC cycles after the column strobe fell.
- R7: `dram_ras_n` stays low for at least T_RAS cycles and `dram_cas_n` for at least T_CAS cycles, in reads and in writes.
- R8: `dram_ras_n` stays high for at least T_RP cycles before it falls again, and two falling edges of `dram_ras_n` are at least T_RC cycles apart.
- R9: While a cycle is running, `req_ready` stays 0 and changes on `req_addr`, `req_write` and `req_wdata` have no effect on the pins of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller is idle and will take a request |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_a | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | DATA_W | Data to the memory's input pins |
| dram_dout | input | DATA_W | Data from the memory's output pins |

## Verification
A behavioural memory model in the bench latches the row and column on the strobe edges. Before both access times have run out it drives inverted data, so a read that samples too early returns a wrong value. Directed operations at the lowest and highest address show whether the row and column halves are swapped or misaligned on the shared pins. A read of a location that was never written, set apart from reads after writes, shows whether the write-enable reached the memory. Seeded random mixes of reads and writes, issued back to back as soon as ready rises, push the cycle spacing down to its minimum. This exposes any shortfall in precharge or total cycle time. Between requests the bench drives junk values with valid low, so any leak of the live request inputs into a running cycle shows up.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ROW_WAIT,
        ST_COL_WAIT,
        ST_PRECHARGE
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_seq_pinmux.sv
module dram_seq_pinmux #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int PIN_W = 4
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             col_sel,
    output logic [PIN_W-1:0] pins
);

    logic [PIN_W-1:0] row_ext;
    logic [PIN_W-1:0] col_ext;

    generate
        if (ROW_W == PIN_W) begin : g_row_full
            assign row_ext = row;
        end else begin : g_row_pad
            assign row_ext = {{(PIN_W-ROW_W){1'b0}}, row};
        end
        if (COL_W == PIN_W) begin : g_col_full
            assign col_ext = col;
        end else begin : g_col_pad
            assign col_ext = {{(PIN_W-COL_W){1'b0}}, col};
        end
    endgenerate

    assign pins = col_sel ? col_ext : row_ext;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_RAS  = 6,
    parameter int T_CAS  = 3,
    parameter int T_RAC  = 5,
    parameter int T_CAC  = 3,
    parameter int T_RP   = 3,
    parameter int T_RC   = 11
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic                                req_write,
    input  logic [ROW_W+COL_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]                   req_wdata,
    output logic                                req_ready,
    output logic                                rsp_valid,
    output logic [DATA_W-1:0]                   rsp_rdata,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
    output logic                                dram_ras_n,
    output logic                                dram_cas_n,
    output logic                                dram_we_n,
    output logic [DATA_W-1:0]                   dram_din,
    input  logic [DATA_W-1:0]                   dram_dout
);

    localparam int AW      = ROW_W + COL_W;
    localparam int PIN_W   = max2(ROW_W, COL_W);
    localparam int COL_CYC = max2(max2(T_CAS, T_CAC), max2(max2(T_RAS - T_RCD, T_RAC - T_RCD), 1));
    localparam int PRE_CYC = max2(max2(T_RP, T_RC - T_RCD - COL_CYC - 2), 1);
    localparam int CNT_W   = $clog2(max2(max2(T_RCD, COL_CYC), PRE_CYC)) + 1;
    localparam int MON_W   = $clog2(T_RC + T_RAS + T_RP + 4) + 1;

    seq_state_t        state_q, state_d;
    logic              wr_q;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              col_sel;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer load on every timed entry
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                state_d  = ST_ROW_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RCD - 1);
            end
            ST_ROW_WAIT: begin
                if (tmr_done) begin
                    state_d  = ST_COL_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(COL_CYC - 1);
                end
            end
            ST_COL_WAIT: begin
                if (tmr_done) begin
                    state_d  = ST_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PRE_CYC - 1);
                end
            end
            ST_PRECHARGE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and read-data sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rsp_q <= (state_q == ST_COL_WAIT) && tmr_done && !wr_q;
            if ((state_q == ST_COL_WAIT) && tmr_done && !wr_q) begin
                rdata_q <= dram_dout;
            end
        end
    end

    dram_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // Column goes on the pins one cycle before the column strobe falls
    assign col_sel = (state_q == ST_COL_WAIT) || ((state_q == ST_ROW_WAIT) && tmr_done);

    dram_seq_pinmux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) pinmux_i (
        .row     (addr_q[AW-1:COL_W]),
        .col     (addr_q[COL_W-1:0]),
        .col_sel (col_sel),
        .pins    (dram_a)
    );

    // Outputs decoded from state
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        dram_ras_n = !((state_q == ST_ROW_WAIT) || (state_q == ST_COL_WAIT));
        dram_cas_n = !(state_q == ST_COL_WAIT);
        dram_we_n  = !(wr_q && (state_q != ST_IDLE));
        dram_din   = wdata_q;
        rsp_valid  = rsp_q;
        rsp_rdata  = rdata_q;
    end

    // Strobe interval monitors, saturating
    logic [MON_W-1:0] ras_lo_cnt, ras_hi_cnt, cas_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= '1;
            cas_lo_cnt <= '0;
        end else begin
            if (dram_ras_n) begin
                ras_lo_cnt <= '0;
                if (ras_hi_cnt != '1) ras_hi_cnt <= ras_hi_cnt + 1'b1;
            end else begin
                ras_hi_cnt <= '0;
                if (ras_lo_cnt != '1) ras_lo_cnt <= ras_lo_cnt + 1'b1;
            end
            if (dram_cas_n) begin
                cas_lo_cnt <= '0;
            end else if (cas_lo_cnt != '1) begin
                cas_lo_cnt <= cas_lo_cnt + 1'b1;
            end
        end
    end

    AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (ras_lo_cnt >= MON_W'(T_RCD))); // R4
    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (ras_lo_cnt >= MON_W'(T_RAS))); // R7
    AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> (cas_lo_cnt >= MON_W'(T_CAS))); // R7
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_cnt >= MON_W'(T_RP))); // R8
    AST_WE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_we_n)); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> !req_ready); // R9
    AST_RSP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> dram_we_n); // R6

endmodule

// File: tb/dram_seq_tb_top.sv
module dram_seq_tb_top;

    localparam int ROW_W  = 4;
    localparam int COL_W  = 4;
    localparam int DATA_W = 8;
    localparam int T_RCD  = 2;
    localparam int T_RAS  = 6;
    localparam int T_CAS  = 3;
    localparam int T_RAC  = 5;
    localparam int T_CAC  = 3;
    localparam int T_RP   = 3;
    localparam int T_RC   = 11;
    localparam int AW     = ROW_W + COL_W;
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int DEPTH  = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [PIN_W-1:0]  dram_a;
    logic              dram_ras_n, dram_cas_n, dram_we_n;
    logic [DATA_W-1:0] dram_din;
    logic [DATA_W-1:0] dram_dout = '0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    dram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_RAC(T_RAC),
        .T_CAC(T_CAC), .T_RP(T_RP), .T_RC(T_RC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_din(dram_din), .dram_dout(dram_dout)
    );

    function automatic logic [PIN_W-1:0] exp_row(input logic [AW-1:0] a);
        return PIN_W'(a[AW-1:COL_W]);
    endfunction

    function automatic logic [PIN_W-1:0] exp_col(input logic [AW-1:0] a);
        return PIN_W'(a[COL_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] init_val(input int i);
        return DATA_W'(i * 37 + 11);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model and reference contents
    logic [DATA_W-1:0] dmem [DEPTH];
    logic [DATA_W-1:0] refm [DEPTH];
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            dmem[i] = init_val(i);
            refm[i] = init_val(i);
        end
    end

    logic              cur_write = 1'b0;
    logic [AW-1:0]     cur_addr = '0;
    logic [DATA_W-1:0] cur_wdata = '0;
    int                rsp_seen = 0;

    // Pin monitor, sampled mid-cycle
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    logic [PIN_W-1:0] m_row = '0, m_col = '0;
    int ncyc = 0, ras_fall_n = 0, ras_rise_n = 0, cas_fall_n = 0;
    int rcnt = 0, ccnt = 0;
    bit seen_fall = 1'b0, seen_rise = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            ncyc++;
            if (prev_ras && !dram_ras_n) begin
                chk(dram_a == exp_row(cur_addr), "R2 row at RAS fall", int'(dram_a), int'(exp_row(cur_addr)));
                if (seen_rise) chk(ncyc - ras_rise_n >= T_RP, "R8 precharge", ncyc - ras_rise_n, T_RP);
                if (seen_fall) chk(ncyc - ras_fall_n >= T_RC, "R8 cycle time", ncyc - ras_fall_n, T_RC);
                seen_fall = 1'b1;
                ras_fall_n = ncyc;
                m_row = dram_a;
                rcnt = 0;
            end else if (!dram_ras_n) begin
                rcnt++;
            end
            if (!prev_ras && dram_ras_n) begin
                chk(ncyc - ras_fall_n >= T_RAS, "R7 RAS width", ncyc - ras_fall_n, T_RAS);
                seen_rise = 1'b1;
                ras_rise_n = ncyc;
            end
            if (prev_cas && !dram_cas_n) begin
                chk(dram_a == exp_col(cur_addr), "R3 col at CAS fall", int'(dram_a), int'(exp_col(cur_addr)));
                chk(ncyc - ras_fall_n >= T_RCD, "R4 RAS to CAS", ncyc - ras_fall_n, T_RCD);
                chk(dram_we_n == !cur_write, "R5/R6 WE at CAS fall", int'(dram_we_n), int'(!cur_write));
                cas_fall_n = ncyc;
                m_col = dram_a;
                ccnt = 0;
                if (!dram_we_n) begin
                    chk(dram_din == cur_wdata, "R5 din at CAS fall", int'(dram_din), int'(cur_wdata));
                    dmem[{m_row[ROW_W-1:0], m_col[COL_W-1:0]}] = dram_din;
                end
            end else if (!dram_cas_n) begin
                ccnt++;
            end
            if (!prev_cas && dram_cas_n) begin
                chk(ncyc - cas_fall_n >= T_CAS, "R7 CAS width", ncyc - cas_fall_n, T_CAS);
            end
            if (!dram_ras_n && !dram_cas_n && dram_we_n) begin
                if (rcnt >= T_RAC - 1 && ccnt >= T_CAC - 1)
                    dram_dout = dmem[{m_row[ROW_W-1:0], m_col[COL_W-1:0]}];
                else
                    dram_dout = ~dmem[{m_row[ROW_W-1:0], m_col[COL_W-1:0]}];
            end else begin
                dram_dout = 8'hA5;
            end
            if (rsp_valid) begin
                rsp_seen++;
                if (cur_write) chk(1'b0, "R5 response on write", 1, 0);
                else chk(rsp_rdata == refm[cur_addr], "R6 read data", int'(rsp_rdata), int'(refm[cur_addr]));
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
        while (!req_ready) @(negedge clk);
        cur_write = w;
        cur_addr  = a;
        cur_wdata = d;
        rsp_seen  = 0;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        chk(!req_ready, "R1 ready drops after accept", int'(req_ready), 0);
        // R9: junk on the request inputs while busy
        req_valid = 1'b0;
        req_write = !w;
        req_addr  = ~a;
        req_wdata = ~d;
        while (!req_ready) @(negedge clk);
        if (w) begin
            refm[a] = d;
            chk(dmem[a] == d, "R5 memory written", int'(dmem[a]), int'(d));
        end
        chk(rsp_seen == (w ? 0 : 1), "R6 response count", rsp_seen, w ? 0 : 1);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: cycles=%0d expected<=%0d", wd, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n == 1'b1, "R1 reset RAS", int'(dram_ras_n), 1);
        chk(dram_cas_n == 1'b1, "R1 reset CAS", int'(dram_cas_n), 1);
        chk(dram_we_n == 1'b1, "R1 reset WE", int'(dram_we_n), 1);
        chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 reset rsp", int'(rsp_valid), 0);

        // Directed corners
        run_op(1'b0, 8'h5A, 8'h00);
        run_op(1'b1, 8'h00, 8'h3C);
        run_op(1'b1, 8'hFF, 8'hC3);
        run_op(1'b0, 8'h00, 8'h00);
        run_op(1'b0, 8'hFF, 8'h00);
        run_op(1'b1, 8'h0F, 8'h81);
        run_op(1'b0, 8'hF0, 8'h00);
        run_op(1'b0, 8'h0F, 8'h00);

        // Seeded random mix, issued back to back
        for (int n = 0; n < 80; n++) begin
            run_op(1'($urandom), AW'($urandom), DATA_W'($urandom));
        end

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule